// File: doc/BRIEF.md
# Way-Guessing Lookup Unit for a Two-Way Instruction Cache

This block decides hit or miss for a two-way set-associative instruction cache without comparing both ways at once. Each set keeps one guess bit that names the way expected to hold the next line asked for. An accepted lookup first compares only the guessed way. When that way holds the line, the result comes back one cycle after acceptance. When it does not, the unit spends two more cycles comparing the other way and returns a slow result. If the other way hits, that set's guess is moved to it. If neither way hits, a miss is reported and the guess is left alone.

Tags and valid bits sit in small internal arrays. A refill port writes a line into the least recently used way of its set and points the set's guess at the way just written. Two saturating counters can be read at the ports: one counts right guesses and one counts wrong guesses.

Top module: `wayguess_lookup`

## Requirements
- R1: After reset every line is invalid, every set guesses way 0, every set's replacement choice is way 0, both counters read 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An address splits into a line offset in bits [OFF_W-1:0], a set index in the next IDX_W bits and a tag in the remaining upper bits. The offset has no effect on any result.
- R3: If the guessed way of the addressed set holds a valid line with a matching tag, then `rsp_valid` is 1 in the cycle after the accepting edge, with `rsp_hit`=1, `rsp_slow`=0 and `rsp_way` equal to the guessed way.
- R4: If the guessed way does not match but the other way does, then `rsp_valid` stays 0 for two cycles and is 1 in the third cycle after the accepting edge, with `rsp_hit`=1, `rsp_slow`=1 and `rsp_way` equal to the other way. From then on the set guesses that other way.
- R5: If neither way matches, the result arrives with the same timing as in R4, with `rsp_hit`=0, `rsp_slow`=1 and `rsp_way` equal to the non-guessed way. The set's guess does not change.
- R6: During the two cycles that follow the acceptance of a lookup whose first comparison failed, `req_ready` is 0 and no request is taken.
- R7: A refill writes the line into the set's replacement way. That way is the one not used most recently, where both a hit and a refill count as a use. After the refill the set guesses the way that was written.
- R8: Each accepted lookup produces exactly one result cycle with `rsp_valid`=1. A refill produces none.
- R9: `cnt_right` increases by one for each fast hit and `cnt_wrong` by one for each slow hit. Misses change neither counter, and both counters stop at their all-ones value.
- R10: A refill is acted on only while the unit is idle. While `fill_valid` is 1, `req_ready` is 0, so the refill takes priority over a lookup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup address |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| fill_valid | input | 1 | Refill request, acted on when idle |
| fill_addr | input | ADDR_W | Address of the line being written |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | 1 = line present |
| rsp_way | output | 1 | Way that hit, or the non-guessed way on a miss |
| rsp_slow | output | 1 | 1 = result came from the second comparison |
| cnt_right | output | CNT_W | Saturating count of right guesses |
| cnt_wrong | output | CNT_W | Saturating count of wrong guesses |

## Verification
A fast hit is due in the cycle right after the accepting edge. A slow hit or a miss is due two cycles later, and `rsp_valid` and `req_ready` must both be 0 in the two cycles between. The bench drives a request at a falling edge and samples at each later falling edge. For each lookup it first works out from its own model of tags, guesses and replacement state whether the result should be fast or slow. It then checks the strobe's absence or presence cycle by cycle, up to the exact cycle where the result is due. The counters are compared with the model only between operations, once every update has landed. A refill offered together with a request is checked to produce no result in the next cycle.

// File: rtl/wayguess_pkg.sv
package wayguess_pkg;

    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PROBE2  = 2'd1,
        ST_RESOLVE = 2'd2
    } lookup_state_e;

    typedef struct packed {
        logic hit;
        logic way;
        logic slow;
    } lookup_rsp_t;

    function automatic logic other_way(input logic w);
        return ~w;
    endfunction

endpackage

// File: rtl/wayguess_tags.sv
module wayguess_tags import wayguess_pkg::*; #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    cmp_idx,
    input  logic [TAG_W-1:0]    cmp_tag,
    output logic [NUM_WAYS-1:0] hit_vec,
    input  logic                wr_en,
    input  logic                wr_way,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [TAG_W-1:0]    wr_tag
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld_q;
        logic             sel;

        assign sel = wr_en && (wr_way == 1'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (sel) begin
                vld_q[wr_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_mem[wr_idx] <= wr_tag;
            end
        end

        assign hit_vec[w] = vld_q[cmp_idx] && (tag_mem[cmp_idx] == cmp_tag);
    end

endmodule

// File: rtl/wayguess_bits.sv
module wayguess_bits #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] pred_rd_idx,
    output logic             pred_rd,
    input  logic [IDX_W-1:0] lru_rd_idx,
    output logic             lru_rd,
    input  logic             pred_wr_en,
    input  logic [IDX_W-1:0] pred_wr_idx,
    input  logic             pred_wr_way,
    input  logic             lru_wr_en,
    input  logic [IDX_W-1:0] lru_wr_idx,
    input  logic             lru_wr_mru
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] victim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
        end else if (pred_wr_en) begin
            pred_q[pred_wr_idx] <= pred_wr_way;
        end
    end

    // victim bit holds the way to replace next: the one not used last
    always_ff @(posedge clk) begin
        if (rst) begin
            victim_q <= '0;
        end else if (lru_wr_en) begin
            victim_q[lru_wr_idx] <= ~lru_wr_mru;
        end
    end

    assign pred_rd = pred_q[pred_rd_idx];
    assign lru_rd  = victim_q[lru_rd_idx];

endmodule

// File: rtl/wayguess_satcnt.sv
module wayguess_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != MAXV)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    p_cnt_hold_max_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAXV) |=> (cnt_q == MAXV));

    p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
        (inc && (cnt_q != MAXV)) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/wayguess_lookup.sv
module wayguess_lookup import wayguess_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_way,
    output logic              rsp_slow,
    output logic [CNT_W-1:0]  cnt_right,
    output logic [CNT_W-1:0]  cnt_wrong
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    lookup_state_e state_q;

    logic [IDX_W-1:0] req_idx, fill_idx, idx_q, cmp_idx;
    logic [TAG_W-1:0] req_tag, fill_tag, tag_q, cmp_tag;
    logic             first_way_q, hit2_q;
    logic [NUM_WAYS-1:0] hit_vec;
    logic             pred_way, victim_way, probe_way, probe_hit;
    logic             in_idle, in_resolve;
    logic             fill_go, accept, fast_hit, slow_hit_done;
    logic             pred_wr_en, pred_wr_way;
    logic [IDX_W-1:0] pred_wr_idx;
    logic             lru_wr_en, lru_wr_mru;
    logic [IDX_W-1:0] lru_wr_idx;
    lookup_rsp_t      rsp_q;
    logic             rsp_valid_q;
    logic             unused_offsets;

    // address fields
    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign fill_idx = fill_addr[OFF_W +: IDX_W];
    assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
    assign unused_offsets = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

    assign in_idle    = (state_q == ST_IDLE);
    assign in_resolve = (state_q == ST_RESOLVE);

    // first probe uses the live request, second probe the latched one
    assign cmp_idx   = in_idle ? req_idx : idx_q;
    assign cmp_tag   = in_idle ? req_tag : tag_q;
    assign probe_way = in_idle ? pred_way : other_way(first_way_q);
    assign probe_hit = hit_vec[probe_way];

    assign fill_go       = in_idle && fill_valid;
    assign req_ready     = in_idle && !fill_valid;
    assign accept        = req_valid && req_ready;
    assign fast_hit      = accept && probe_hit;
    assign slow_hit_done = in_resolve && hit2_q;

    // guess updates: refill points at written way, slow hit at the other way
    assign pred_wr_en  = fill_go || slow_hit_done;
    assign pred_wr_idx = fill_go ? fill_idx : idx_q;
    assign pred_wr_way = fill_go ? victim_way : other_way(first_way_q);

    // recency updates: every hit and every refill marks a way as used
    assign lru_wr_en  = fill_go || fast_hit || slow_hit_done;
    assign lru_wr_idx = fill_go ? fill_idx : (fast_hit ? req_idx : idx_q);
    assign lru_wr_mru = fill_go ? victim_way
                      : (fast_hit ? pred_way : other_way(first_way_q));

    wayguess_tags #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk     (clk),
        .rst     (rst),
        .cmp_idx (cmp_idx),
        .cmp_tag (cmp_tag),
        .hit_vec (hit_vec),
        .wr_en   (fill_go),
        .wr_way  (victim_way),
        .wr_idx  (fill_idx),
        .wr_tag  (fill_tag)
    );

    wayguess_bits #(
        .IDX_W (IDX_W)
    ) u_bits (
        .clk         (clk),
        .rst         (rst),
        .pred_rd_idx (req_idx),
        .pred_rd     (pred_way),
        .lru_rd_idx  (fill_idx),
        .lru_rd      (victim_way),
        .pred_wr_en  (pred_wr_en),
        .pred_wr_idx (pred_wr_idx),
        .pred_wr_way (pred_wr_way),
        .lru_wr_en   (lru_wr_en),
        .lru_wr_idx  (lru_wr_idx),
        .lru_wr_mru  (lru_wr_mru)
    );

    wayguess_satcnt #(.W(CNT_W)) u_cnt_right (
        .clk (clk),
        .rst (rst),
        .inc (fast_hit),
        .cnt (cnt_right)
    );

    wayguess_satcnt #(.W(CNT_W)) u_cnt_wrong (
        .clk (clk),
        .rst (rst),
        .inc (slow_hit_done),
        .cnt (cnt_wrong)
    );

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            tag_q       <= '0;
            first_way_q <= 1'b0;
            hit2_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept && !probe_hit) begin
                        state_q     <= ST_PROBE2;
                        idx_q       <= req_idx;
                        tag_q       <= req_tag;
                        first_way_q <= pred_way;
                    end
                end
                ST_PROBE2: begin
                    hit2_q  <= probe_hit;
                    state_q <= ST_RESOLVE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // result register
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_q       <= '0;
        end else begin
            rsp_valid_q <= fast_hit || in_resolve;
            if (fast_hit) begin
                rsp_q <= '{hit: 1'b1, way: pred_way, slow: 1'b0};
            end else if (in_resolve) begin
                rsp_q <= '{hit: hit2_q, way: other_way(first_way_q), slow: 1'b1};
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_way   = rsp_q.way;
    assign rsp_slow  = rsp_q.slow;

    p_fast_result_r3: assert property (@(posedge clk) disable iff (rst)
        fast_hit |=> (rsp_valid && rsp_hit && !rsp_slow));

    p_slow_after_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_slow) |-> $past(!req_ready));

    p_busy_two_cycles_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && !probe_hit) |=> !req_ready ##1 !req_ready);

    p_fill_no_result_r10: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> !rsp_valid);

endmodule

// File: tb/wayguess_lookup_bench.sv
module wayguess_lookup_bench;
    localparam int ADDR_W = 16;
    localparam int OFF_W  = 2;
    localparam int IDX_W  = 4;
    localparam int CNT_W  = 8;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int SETS   = 1 << IDX_W;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic              rsp_valid, rsp_hit, rsp_way, rsp_slow;
    logic [CNT_W-1:0]  cnt_right, cnt_wrong;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model
    bit               m_vld  [2][SETS];
    logic [TAG_W-1:0] m_tag  [2][SETS];
    bit               m_pred [SETS];
    bit               m_vict [SETS];
    int               m_right = 0;
    int               m_wrong = 0;

    always #2.5 clk = ~clk;

    wayguess_lookup #(
        .ADDR_W (ADDR_W), .OFF_W (OFF_W), .IDX_W (IDX_W), .CNT_W (CNT_W)
    ) u_wayguess_lookup (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_addr (req_addr), .req_ready (req_ready),
        .fill_valid (fill_valid), .fill_addr (fill_addr),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_way (rsp_way),
        .rsp_slow (rsp_slow),
        .cnt_right (cnt_right), .cnt_wrong (cnt_wrong)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
        return {TAG_W'(tag), IDX_W'(idx), OFF_W'(off)};
    endfunction

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic model_lookup(input logic [ADDR_W-1:0] a, output bit ehit,
                                output bit eslow, output bit eway);
        int idx = int'(a[OFF_W +: IDX_W]);
        logic [TAG_W-1:0] t = a[ADDR_W-1 -: TAG_W];
        bit p = m_pred[idx];
        bit o = ~p;
        if (m_vld[p][idx] && m_tag[p][idx] == t) begin
            ehit = 1; eslow = 0; eway = p;
            m_vict[idx] = o; m_right++;
        end else if (m_vld[o][idx] && m_tag[o][idx] == t) begin
            ehit = 1; eslow = 1; eway = o;
            m_pred[idx] = o; m_vict[idx] = p; m_wrong++;
        end else begin
            ehit = 0; eslow = 1; eway = o;
        end
    endtask

    task automatic do_lookup(input logic [ADDR_W-1:0] a, input string req);
        bit ehit, eslow, eway;
        model_lookup(a, ehit, eslow, eway);
        @(negedge clk);
        chk(req_ready == 1'b1, "R6", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!eslow) begin
            chk(rsp_valid == 1'b1, req, "fast strobe", int'(rsp_valid), 1);
            chk(rsp_hit == 1'b1 && rsp_slow == 1'b0, req, "fast hit/slow",
                int'({rsp_hit, rsp_slow}), 2);
            chk(rsp_way == eway, req, "fast way", int'(rsp_way), int'(eway));
        end else begin
            chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R6", "stall cycle 1",
                int'({rsp_valid, req_ready}), 0);
            @(negedge clk);
            chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R6", "stall cycle 2",
                int'({rsp_valid, req_ready}), 0);
            @(negedge clk);
            chk(rsp_valid == 1'b1 && rsp_slow == 1'b1, req, "slow strobe",
                int'({rsp_valid, rsp_slow}), 3);
            chk(rsp_hit == ehit, ehit ? "R4" : "R5", "slow hit flag",
                int'(rsp_hit), int'(ehit));
            chk(rsp_way == eway, ehit ? "R4" : "R5", "slow way",
                int'(rsp_way), int'(eway));
        end
    endtask

    task automatic do_fill(input logic [ADDR_W-1:0] a, input bit with_req);
        int idx = int'(a[OFF_W +: IDX_W]);
        bit w = m_vict[idx];
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        if (with_req) begin
            req_valid = 1'b1;
            req_addr  = a;
            #1;
            chk(req_ready == 1'b0, "R10", "ready with fill", int'(req_ready), 0);
        end
        @(negedge clk);
        fill_valid = 1'b0;
        req_valid  = 1'b0;
        chk(rsp_valid == 1'b0, with_req ? "R10" : "R8", "no strobe after fill",
            int'(rsp_valid), 0);
        m_vld[w][idx]  = 1;
        m_tag[w][idx]  = a[ADDR_W-1 -: TAG_W];
        m_pred[idx]    = w;
        m_vict[idx]    = ~w;
    endtask

    task automatic check_counters(input string tag);
        @(negedge clk);
        chk(int'(cnt_right) == sat(m_right), "R9", {tag, " right count"},
            int'(cnt_right), sat(m_right));
        chk(int'(cnt_wrong) == sat(m_wrong), "R9", {tag, " wrong count"},
            int'(cnt_wrong), sat(m_wrong));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int s = 0; s < SETS; s++) begin
            m_pred[s] = 0; m_vict[s] = 0;
            for (int w = 0; w < 2; w++) begin m_vld[w][s] = 0; m_tag[w][s] = '0; end
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ready/strobe after reset",
            int'({req_ready, rsp_valid}), 2);
        chk(cnt_right == '0 && cnt_wrong == '0, "R1", "counters after reset",
            int'(cnt_right) + int'(cnt_wrong), 0);
        // R1/R5: empty cache misses, non-guessed way is 1
        do_lookup(mk(5, 3, 0), "R1");
        // R7: first refill goes to way 0, then fast hit
        do_fill(mk(5, 3, 0), 0);
        do_lookup(mk(5, 3, 0), "R3");
        // R7: second line lands in way 1, guess follows it
        do_fill(mk(9, 3, 1), 0);
        do_lookup(mk(9, 3, 2), "R7");
        // R4: line in way 0 found slowly, guess moves
        do_lookup(mk(5, 3, 0), "R4");
        do_lookup(mk(5, 3, 3), "R4");
        // R2: offsets do not matter
        for (int o = 0; o < 4; o++) do_lookup(mk(5, 3, o), "R2");
        // R5: miss keeps the guess
        do_lookup(mk(12, 3, 0), "R5");
        do_lookup(mk(5, 3, 1), "R5");
        // R10: refill alongside a request; refill wins, victim is way 1
        do_fill(mk(20, 3, 0), 1);
        do_lookup(mk(20, 3, 0), "R10");
        do_lookup(mk(9, 3, 0), "R7");
        check_counters("directed");
        // random mix
        for (int n = 0; n < 700; n++) begin
            logic [ADDR_W-1:0] a = mk(1 + int'($urandom_range(0, 3)),
                                      ($urandom_range(0, 1) != 0) ? 6 : 11,
                                      int'($urandom_range(0, 3)));
            if ($urandom_range(0, 3) == 0) do_fill(a, $urandom_range(0, 3) == 0);
            else do_lookup(a, "R4");
        end
        check_counters("random");
        // R9: saturate the right-guess counter
        do_fill(mk(33, 9, 0), 0);
        for (int n = 0; n < 300; n++) do_lookup(mk(33, 9, 0), "R9");
        check_counters("saturated");
        chk(int'(cnt_right) == CMAX, "R9", "right count at max", int'(cnt_right), CMAX);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule